// File: doc/BRIEF.md
# Capability Bounds and Permission Checker

This block decides whether one memory access or branch target may go ahead through a tagged capability. A capability arrives as 128 data bits plus one validity tag, 129 bits in all. Its bounds come in compressed form: a small exponent and two 14-bit mantissas for the bottom and the top. The block expands them against the access address in the same cycle that the address arrives from the address generator. It then compares the access window with the expanded range and checks the permission that the access kind needs.

One cycle after the request strobe the block reports either a pass or a fault with a two-bit cause. On a fault it also loads the full 64-bit faulting address into a fault address register. That register keeps its value until a fault overwrites it or a clear request empties it. A load/store unit uses the block on every capability-based access, and a fetch unit uses it on every branch target.

Top module: `cap_access_checker`

## Requirements
- R1: A request whose tag bit is 0 faults with cause 1 (tag), whatever the permission and bounds say. A tag fault outranks every other cause.
- R2: Kind code 0 (load) needs permission bit 0, kind 1 (store) needs bit 1, and kind 2 or 3 (fetch) needs bit 2. A missing bit faults with cause 3 (permission). Cause 3 outranks the bounds cause.
- R3: The lower 64 capability bits hold the permissions in [17:0], the exponent E in [23:18], the bottom B in [37:24] and the top T in [51:38]. Let S = E+14. The base is the address with its low S bits cleared, ORed with B<<E. The limit is formed the same way with T. When the 14-bit address slice starting at bit E is below B, both base and limit move down by one 2^S region.
- R4: When T < B, the limit moves up by one 2^S region.
- R5: An access is legal when base <= address and address + size <= limit, with size counted in bytes. A limit of exactly 2^64 can be represented. A failed range check faults with cause 2 (bounds).
- R6: An exponent field above 50 acts exactly as if it were 50.
- R7: The result appears on the clock edge after the edge that samples req_valid, and it lasts one cycle. rsp_ok and rsp_fault are mutually exclusive. When rsp_valid is 0, rsp_ok, rsp_fault and rsp_cause are all 0. A passing result has cause 0.
- R8: far_addr takes the request address on the edge that reports a fault, and it holds its value on every other edge. far_clr sets it to 0. If a fault and far_clr fall on the same edge, the fault wins. The reset value is 0.
- R9: Capability bits [127:52] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_cap | input | 128 | Capability data bits |
| req_tag | input | 1 | Capability validity tag |
| req_addr | input | 64 | Effective address of the access |
| req_size | input | 8 | Access size in bytes |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| far_clr | input | 1 | Clear the fault address register |
| rsp_valid | output | 1 | Result valid |
| rsp_ok | output | 1 | Access legal |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 tag, 2 bounds, 3 permission |
| far_addr | output | 64 | Captured faulting address |

## Verification
The fault capture into the fault address register and a clear request can land on the same edge. The bench provokes this by driving a faulting request with far_clr set, and it expects far_addr to hold the new faulting address rather than 0. It also drives a passing request together with far_clr, where the clear must take effect. It drives a bare clear as well, and in each case it reads far_addr on the following cycle.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_TAG    = 2'd1,
      CAUSE_BOUNDS = 2'd2,
      CAUSE_PERM   = 2'd3
   } cause_e;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_FETCH_ALT = 2'd3
   } kind_e;

   localparam int PBIT_LOAD  = 0;
   localparam int PBIT_STORE = 1;
   localparam int PBIT_EXEC  = 2;

endpackage

// File: rtl/cap_bounds_expand.sv
module cap_bounds_expand #(
   parameter int ADDR_W  = 64,
   parameter int EXP_W   = 6,
   parameter int MANT_W  = 14,
   parameter int EXP_MAX = 50,
   parameter int WIDE_W  = ADDR_W + 2
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic [EXP_W-1:0]         exp_raw,
   input  logic [MANT_W-1:0]        bot,
   input  logic [MANT_W-1:0]        top,
   output logic signed [WIDE_W-1:0] base,
   output logic signed [WIDE_W-1:0] limit
);

   localparam int SH_W = $clog2(EXP_MAX + MANT_W + 1);

   logic [EXP_W-1:0] exp_eff;

   generate
      if (((1 << EXP_W) - 1) > EXP_MAX) begin : g_clamp
         assign exp_eff = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;
      end else begin : g_pass
         assign exp_eff = exp_raw;
      end
   endgenerate

   logic [SH_W-1:0]          sh;
   logic [WIDE_W-1:0]        addr_wide;
   logic [MANT_W-1:0]        mid;
   logic signed [WIDE_W-1:0] region;
   logic signed [WIDE_W-1:0] region_top;
   logic                     wrap;

   always_comb begin
      sh        = SH_W'(exp_eff) + SH_W'(MANT_W);
      addr_wide = {{(WIDE_W-ADDR_W){1'b0}}, addr};
      mid       = MANT_W'(addr >> exp_eff);
      wrap      = (top < bot);
      region    = $signed(addr_wide >> sh);
      if (mid < bot) begin
         region = region - WIDE_W'(1);
      end
      region_top = wrap ? (region + WIDE_W'(1)) : region;
      base  = (region << sh) | (WIDE_W'(bot) << exp_eff);
      limit = (region_top << sh) | (WIDE_W'(top) << exp_eff);
   end

endmodule

// File: rtl/cap_range_cmp.sv
module cap_range_cmp #(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 8,
   parameter int WIDE_W = ADDR_W + 2
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic [SIZE_W-1:0]        size,
   input  logic signed [WIDE_W-1:0] base,
   input  logic signed [WIDE_W-1:0] limit,
   output logic                     in_bounds
);

   logic signed [WIDE_W-1:0] lo_edge;
   logic signed [WIDE_W-1:0] hi_edge;

   always_comb begin
      lo_edge   = $signed({{(WIDE_W-ADDR_W){1'b0}}, addr});
      hi_edge   = lo_edge + $signed(WIDE_W'(size));
      in_bounds = (base <= lo_edge) && (hi_edge <= limit);
   end

endmodule

// File: rtl/cap_fault_sel.sv
module cap_fault_sel
   import cap_chk_pkg::*;
#(
   parameter int PERM_W = 18
) (
   input  logic              tag,
   input  logic [PERM_W-1:0] perms,
   input  logic [1:0]        kind,
   input  logic              in_bounds,
   output cause_e            cause
);

   logic need_ok;
   logic unused_perm_hi;

   assign unused_perm_hi = ^perms[PERM_W-1:PBIT_EXEC+1];

   always_comb begin
      case (kind_e'(kind))
         KIND_LOAD:  need_ok = perms[PBIT_LOAD];
         KIND_STORE: need_ok = perms[PBIT_STORE];
         default:    need_ok = perms[PBIT_EXEC];
      endcase
      if (!tag) begin
         cause = CAUSE_TAG;
      end else if (!need_ok) begin
         cause = CAUSE_PERM;
      end else if (!in_bounds) begin
         cause = CAUSE_BOUNDS;
      end else begin
         cause = CAUSE_NONE;
      end
   end

endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
   import cap_chk_pkg::*;
#(
   parameter int CAP_W   = 128,
   parameter int ADDR_W  = 64,
   parameter int SIZE_W  = 8,
   parameter int PERM_W  = 18,
   parameter int EXP_W   = 6,
   parameter int MANT_W  = 14,
   parameter int EXP_MAX = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CAP_W-1:0]  req_cap,
   input  logic              req_tag,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [1:0]        req_kind,
   input  logic              far_clr,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic [ADDR_W-1:0] far_addr
);

   localparam int WIDE_W = ADDR_W + 2;
   localparam int P_LO   = 0;
   localparam int E_LO   = P_LO + PERM_W;
   localparam int B_LO   = E_LO + EXP_W;
   localparam int T_LO   = B_LO + MANT_W;
   localparam int F_END  = T_LO + MANT_W;

   generate
      if (EXP_MAX + MANT_W != ADDR_W) begin : g_bad_exp
         $error("EXP_MAX + MANT_W must equal ADDR_W");
      end
      if (F_END > CAP_W / 2) begin : g_bad_fields
         $error("compressed bounds must fit in the lower half of the capability");
      end
      if (PERM_W < 3) begin : g_bad_perm
         $error("PERM_W must hold load, store and execute bits");
      end
      if (EXP_MAX >= (1 << EXP_W)) begin : g_bad_expw
         $error("EXP_W too narrow for EXP_MAX");
      end
   endgenerate

   logic                     unused_cap_hi;
   logic signed [WIDE_W-1:0] exp_base;
   logic signed [WIDE_W-1:0] exp_limit;
   logic                     in_bounds;
   cause_e                   cause_now;
   logic                     fault_now;
   logic [1:0]               cause_q;

   assign unused_cap_hi = ^req_cap[CAP_W-1:F_END];

   cap_bounds_expand #(
      .ADDR_W (ADDR_W),
      .EXP_W  (EXP_W),
      .MANT_W (MANT_W),
      .EXP_MAX(EXP_MAX),
      .WIDE_W (WIDE_W)
   ) i_expand (
      .addr   (req_addr),
      .exp_raw(req_cap[E_LO +: EXP_W]),
      .bot    (req_cap[B_LO +: MANT_W]),
      .top    (req_cap[T_LO +: MANT_W]),
      .base   (exp_base),
      .limit  (exp_limit)
   );

   cap_range_cmp #(
      .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W),
      .WIDE_W(WIDE_W)
   ) i_cmp (
      .addr     (req_addr),
      .size     (req_size),
      .base     (exp_base),
      .limit    (exp_limit),
      .in_bounds(in_bounds)
   );

   cap_fault_sel #(
      .PERM_W(PERM_W)
   ) i_sel (
      .tag      (req_tag),
      .perms    (req_cap[P_LO +: PERM_W]),
      .kind     (req_kind),
      .in_bounds(in_bounds),
      .cause    (cause_now)
   );

   assign fault_now = (cause_now != CAUSE_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         cause_q   <= CAUSE_NONE;
         far_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         cause_q   <= req_valid ? cause_now : CAUSE_NONE;
         if (req_valid && fault_now) begin
            far_addr <= req_addr;
         end else if (far_clr) begin
            far_addr <= '0;
         end
      end
   end

   assign rsp_cause = cause_q;
   assign rsp_ok    = rsp_valid && (cause_q == CAUSE_NONE);
   assign rsp_fault = rsp_valid && (cause_q != CAUSE_NONE);

endmodule

// File: rtl/cap_access_checker_sva.sv
module cap_access_checker_sva #(
   parameter int CAP_W  = 128,
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_tag,
   input logic [ADDR_W-1:0] req_addr,
   input logic              far_clr,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic              rsp_fault,
   input logic [1:0]        rsp_cause,
   input logic [ADDR_W-1:0] far_addr
);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                        // R7
   AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                      // R7
   AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ok != rsp_fault));                            // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_ok && !rsp_fault && rsp_cause == 2'd0));    // R7
   AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok |-> (rsp_cause == 2'd0));                                 // R7
   AST_UNTAGGED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_tag) |=> (rsp_fault && rsp_cause == 2'd1));   // R1
   AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (far_addr == $past(req_addr)));                    // R8
   AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !far_clr) |=> $stable(far_addr));                 // R8

endmodule

bind cap_access_checker cap_access_checker_sva #(
   .CAP_W (CAP_W),
   .ADDR_W(ADDR_W)
) i_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_tag  (req_tag),
   .req_addr (req_addr),
   .far_clr  (far_clr),
   .rsp_valid(rsp_valid),
   .rsp_ok   (rsp_ok),
   .rsp_fault(rsp_fault),
   .rsp_cause(rsp_cause),
   .far_addr (far_addr)
);

// File: tb/test_cap_access_checker.sv
module test_cap_access_checker;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [1:0]  cause;
      logic [63:0] far;
      string       tagname;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [127:0]  req_cap = '0;
   logic          req_tag = 1'b0;
   logic [63:0]   req_addr = '0;
   logic [7:0]    req_size = '0;
   logic [1:0]    req_kind = '0;
   logic          far_clr = 1'b0;
   logic          rsp_valid;
   logic          rsp_ok;
   logic          rsp_fault;
   logic [1:0]    rsp_cause;
   logic [63:0]   far_addr;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 0;
   logic [63:0] model_far = '0;
   exp_t scb[$];

   cap_access_checker i_cap_access_checker (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_cap  (req_cap),
      .req_tag  (req_tag),
      .req_addr (req_addr),
      .req_size (req_size),
      .req_kind (req_kind),
      .far_clr  (far_clr),
      .rsp_valid(rsp_valid),
      .rsp_ok   (rsp_ok),
      .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause),
      .far_addr (far_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [127:0] mk_cap(logic [17:0] p, logic [5:0] e,
                                           logic [13:0] b, logic [13:0] t,
                                           logic [75:0] hi);
      return {hi, t, b, e, p};
   endfunction

   function automatic logic [1:0] model(logic [127:0] cap, logic tag,
                                        logic [63:0] addr, logic [7:0] size,
                                        logic [1:0] kind);
      int e;
      int sh;
      int pidx;
      logic [13:0] b;
      logic [13:0] t;
      logic [13:0] mid;
      logic signed [69:0] av;
      logic signed [69:0] rg;
      logic signed [69:0] bs;
      logic signed [69:0] lm;
      logic signed [69:0] en;
      if (!tag) return 2'd1;
      pidx = (kind == 2'd0) ? 0 : (kind == 2'd1) ? 1 : 2;
      if (!cap[pidx]) return 2'd3;
      e = int'(cap[23:18]);
      if (e > 50) e = 50;
      sh  = e + 14;
      b   = cap[37:24];
      t   = cap[51:38];
      mid = 14'(addr >> e);
      av  = $signed({6'b0, addr});
      rg  = $signed(70'({6'b0, addr} >> sh));
      if (mid < b) rg = rg - 70'sd1;
      bs = (rg <<< sh) + $signed(70'(b) << e);
      if (t < b) rg = rg + 70'sd1;
      lm = (rg <<< sh) + $signed(70'(t) << e);
      en = av + $signed(70'(size));
      if (bs <= av && en <= lm) return 2'd0;
      return 2'd2;
   endfunction

   task automatic check(bit cond, string req, string what, logic [63:0] act, logic [63:0] expv);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic drive(logic [127:0] cap, logic tag, logic [63:0] addr,
                        logic [7:0] size, logic [1:0] kind, logic clr, string tagname);
      exp_t it;
      @(negedge clk);
      req_valid = 1'b1;
      req_cap   = cap;
      req_tag   = tag;
      req_addr  = addr;
      req_size  = size;
      req_kind  = kind;
      far_clr   = clr;
      it.cause  = model(cap, tag, addr, size, kind);
      if (it.cause != 2'd0) model_far = addr;
      else if (clr) model_far = '0;
      it.far     = model_far;
      it.tagname = tagname;
      scb.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      far_clr   = 1'b0;
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && rsp_valid) begin
         if (scb.size() == 0) begin
            check(1'b0, "R7", "unexpected response", 64'(rsp_cause), 64'd0);
         end else begin
            exp_t it;
            it = scb.pop_front();
            check(rsp_cause == it.cause, it.tagname, "cause", 64'(rsp_cause), 64'(it.cause));
            check(rsp_ok == (it.cause == 2'd0) && rsp_fault == (it.cause != 2'd0),
                  it.tagname, "ok/fault", {62'd0, rsp_ok, rsp_fault},
                  {62'd0, it.cause == 2'd0, it.cause != 2'd0});
            check(far_addr == it.far, it.tagname, "far_addr", far_addr, it.far);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] c_lo;
      logic [127:0] c_wr;
      logic [127:0] c_hi;
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0 && rsp_ok == 1'b0 && rsp_fault == 1'b0, "R7", "reset outputs",
            {61'd0, rsp_valid, rsp_ok, rsp_fault}, 64'd0);
      check(far_addr == 64'd0, "R8", "reset far", far_addr, 64'd0);
      rst_n = 1'b1;
      idle();

      // E=0, B=0x100, T=0x200, all permissions: window 0x...100 to 0x...200
      c_lo = mk_cap(18'h7, 6'd0, 14'h100, 14'h200, 76'd0);
      drive(c_lo, 1'b1, 64'h1000_0150, 8'd8, 2'd0, 1'b0, "R3 in-bounds load");
      drive(c_lo, 1'b1, 64'h1000_01F8, 8'd8, 2'd1, 1'b0, "R5 end equals limit");
      drive(c_lo, 1'b1, 64'h1000_01F8, 8'd9, 2'd0, 1'b0, "R5 one byte past limit");
      drive(c_lo, 1'b1, 64'h1000_00FF, 8'd1, 2'd0, 1'b0, "R3 slice below bottom");
      drive(c_lo, 1'b1, 64'h1000_0100, 8'd0, 2'd2, 1'b0, "R5 base exact fetch");
      // tag clear beats missing permission and out-of-range
      drive(mk_cap(18'h0, 6'd0, 14'h100, 14'h200, 76'd0), 1'b0, 64'hDEAD_0000, 8'd8, 2'd0,
            1'b0, "R1 untagged");
      // permission missing beats out-of-range
      drive(mk_cap(18'h6, 6'd0, 14'h100, 14'h200, 76'd0), 1'b1, 64'hBEEF_0000, 8'd8, 2'd0,
            1'b0, "R2 no load perm");
      drive(mk_cap(18'h5, 6'd0, 14'h100, 14'h200, 76'd0), 1'b1, 64'h1000_0150, 8'd8, 2'd1,
            1'b0, "R2 no store perm");
      drive(mk_cap(18'h3, 6'd0, 14'h100, 14'h200, 76'd0), 1'b1, 64'h1000_0150, 8'd4, 2'd3,
            1'b0, "R2 no exec perm");
      drive(mk_cap(18'h4, 6'd0, 14'h100, 14'h200, 76'd0), 1'b1, 64'h1000_0150, 8'd4, 2'd2,
            1'b0, "R2 exec perm only fetch");
      // T < B wrap with region correction: window 0x0FFF_FF00 .. 0x1000_0100
      c_wr = mk_cap(18'h7, 6'd0, 14'h3F00, 14'h0100, 76'd0);
      drive(c_wr, 1'b1, 64'h1000_0050, 8'd16, 2'd0, 1'b0, "R4 wrap above seam");
      drive(c_wr, 1'b1, 64'h0FFF_FF80, 8'd16, 2'd0, 1'b0, "R4 wrap below seam");
      drive(c_wr, 1'b1, 64'h1000_00F8, 8'd9, 2'd0, 1'b0, "R4 wrap past top");
      // limit of 2^64: E=50, B=1, T=0
      c_hi = mk_cap(18'h7, 6'd50, 14'h0001, 14'h0000, 76'd0);
      drive(c_hi, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 8'd8, 2'd0, 1'b0, "R5 limit 2^64");
      drive(c_hi, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 8'd9, 2'd0, 1'b0, "R5 beyond 2^64");
      // exponent clamp: E=63 behaves as E=50
      drive(mk_cap(18'h7, 6'd63, 14'h0000, 14'h2000, 76'd0), 1'b1, 64'h7FFF_FFFF_FFFF_FFF0,
            8'd16, 2'd0, 1'b0, "R6 clamp in range");
      drive(mk_cap(18'h7, 6'd63, 14'h0000, 14'h2000, 76'd0), 1'b1, 64'h8000_0000_0000_0000,
            8'd1, 2'd0, 1'b0, "R6 clamp out of range");
      drive(mk_cap(18'h7, 6'd55, 14'h0001, 14'h0000, 76'd0), 1'b1, 64'h0008_0000_0000_0000,
            8'd1, 2'd0, 1'b0, "R6 clamp base");
      // upper capability bits ignored
      drive(mk_cap(18'h7, 6'd0, 14'h100, 14'h200, {76{1'b1}}), 1'b1, 64'h1000_0150, 8'd8, 2'd0,
            1'b0, "R9 upper ones pass");
      drive(mk_cap(18'h7, 6'd0, 14'h100, 14'h200, 76'hA_5A5A_5A5A_5A5A_5A5A_5),
            1'b1, 64'h1000_0250, 8'd8, 2'd0, 1'b0, "R9 upper noise fault");
      // fault and clear on the same edge: fault wins
      drive(c_lo, 1'b1, 64'h2222_0000, 8'd4, 2'd0, 1'b1, "R8 fault beats clear");
      // pass with clear: clear acts
      drive(c_lo, 1'b1, 64'h1000_0150, 8'd4, 2'd0, 1'b1, "R8 clear on pass");
      drive(c_lo, 1'b1, 64'h3333_0000, 8'd4, 2'd0, 1'b0, "R8 new fault");
      drive(c_lo, 1'b1, 64'h1000_0150, 8'd4, 2'd0, 1'b0, "R8 pass holds far");
      idle();
      idle();
      check(far_addr == model_far, "R8", "far held while idle", far_addr, model_far);
      @(negedge clk);
      far_clr = 1'b1;
      @(negedge clk);
      far_clr = 1'b0;
      model_far = '0;
      check(far_addr == 64'd0, "R8", "bare clear", far_addr, 64'd0);
      check(rsp_valid == 1'b0 && rsp_cause == 2'd0, "R7", "idle quiet",
            {61'd0, rsp_valid, rsp_cause}, 64'd0);

      for (int i = 0; i < 300; i++) begin
         logic [5:0]  e;
         logic [13:0] b;
         logic [13:0] t;
         logic [63:0] a;
         e = 6'($urandom_range(0, 63));
         b = 14'($urandom);
         t = 14'($urandom);
         a = {$urandom, $urandom};
         if (i % 2 == 0) a = (a & ~(64'h3FFF << e)) | (64'(b + 14'(($urandom % 8))) << e);
         drive(mk_cap(18'($urandom), e, b, t, {44'($urandom), $urandom}),
               ($urandom % 8) != 0, a, 8'($urandom), 2'($urandom), 1'($urandom % 4 == 0),
               "R5 random mix");
      end
      idle();
      idle();
      idle();
      check(scb.size() == 0, "R7", "all responses seen", 64'(scb.size()), 64'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule